// File: doc/BRIEF.md
# Twin-Port Memory with External Write Hold

This block is a synchronous true dual-port memory of 1024 words of 8 bits. Its two sides, left and right, are fully independent. Each side has its own address, write data, registered read data, an active-low select, an active-low output enable and a read/write line. Either side can reach every word.

Each side also has an active-low hold input. While a side's hold is low, a write from that side is dropped inside the block. This lets several of these memories sit behind one external arbiter, so that all of them follow a single arbitration decision.

Output enable does not drive a pad. It qualifies the data: a read-valid flag rises only for a read that was accepted. A per-side standby flag reports, one clock later, that the side is deselected.

Top module: `twin_port_ram`

## Requirements
- R1: Any of the 1024 words, including addresses 0x000 and 0x3FF, can be written through one side and read back through the other.
- R2: A side accepts a read in a cycle where its select is 0, its read/write line is 1 and its output enable is 0. One clock later its read data hold the addressed word and its read-valid flag is 1. The word is read as it stood before any write in the same cycle.
- R3: A side's read-valid flag is 0 in the cycle after any cycle that was not an accepted read. This covers output enable at 1, select at 1, and a write, so the data are never qualified while that side writes.
- R4: A side's read data keep the value of its last accepted read until that side accepts another read.
- R5: A side writes its data to the addressed word when its select is 0, its read/write line is 0 and its hold is 1, whatever the level of its output enable.
- R6: While a side's hold input is 0, a write from that side leaves the memory unchanged.
- R7: While a side's select is 1, that side makes no transaction: a read/write line at 0 writes nothing.
- R8: When both sides write the same address in one cycle and neither is held, the left side's data are stored.
- R9: A side's standby flag equals that side's select level of the previous clock.
- R10: After reset, both read-valid flags are 0, both read data are 0x00 and both standby flags are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| l_cs_n | input | 1 | Left select, active low |
| l_oe_n | input | 1 | Left output enable, active low |
| l_read | input | 1 | Left read/write line: 1 read, 0 write |
| l_hold_n | input | 1 | Left write hold, active low |
| l_addr | input | 10 | Left word address |
| l_wdata | input | 8 | Left write data |
| l_rdata | output | 8 | Left registered read data |
| l_rvalid | output | 1 | Left read data qualifier |
| l_standby | output | 1 | Left deselected flag |
| r_cs_n | input | 1 | Right select, active low |
| r_oe_n | input | 1 | Right output enable, active low |
| r_read | input | 1 | Right read/write line: 1 read, 0 write |
| r_hold_n | input | 1 | Right write hold, active low |
| r_addr | input | 10 | Right word address |
| r_wdata | input | 8 | Right write data |
| r_rdata | output | 8 | Right registered read data |
| r_rvalid | output | 1 | Right read data qualifier |
| r_standby | output | 1 | Right deselected flag |

## Verification
Read data, the read-valid flag and the standby flag each pass through one register, so all three are due exactly one clock after the cycle that caused them. A write becomes visible to a read issued in the following cycle. The bench drives every request on the falling edge and checks at the next falling edge, which lands one rising edge after the request. Write effects, including held, deselected and colliding writes, are checked with a later read and compared against a reference array kept in the bench.

// File: rtl/twin_port_pkg.sv
package twin_port_pkg;

  typedef struct packed {
    logic cs_n;
    logic oe_n;
    logic read;
    logic hold_n;
  } port_ctl_t;

  function automatic logic want_read(input port_ctl_t c);
    return !c.cs_n && c.read && !c.oe_n;
  endfunction

  function automatic logic want_write(input port_ctl_t c);
    return !c.cs_n && !c.read && c.hold_n;
  endfunction

endpackage

// File: rtl/port_decode.sv
module port_decode
  import twin_port_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  port_ctl_t ctl,
  output logic      rd_en,
  output logic      wr_en,
  output logic      rvalid,
  output logic      standby
);

  assign rd_en = want_read(ctl);
  assign wr_en = want_write(ctl);

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid  <= 1'b0;
      standby <= 1'b1;
    end else begin
      rvalid  <= rd_en;
      standby <= ctl.cs_n;
    end
  end

endmodule

// File: rtl/twin_port_array.sv
module twin_port_array #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  input  logic              a_we,
  input  logic              a_re,
  output logic [DATA_W-1:0] a_rdata,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  input  logic              b_we,
  input  logic              b_re,
  output logic [DATA_W-1:0] b_rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic              clash;

  // side A (left) wins a same-address double write
  assign clash = a_we && b_we && (a_addr == b_addr);

  always_ff @(posedge clk) begin
    if (b_we && !clash) mem[b_addr] <= b_wdata;
    if (a_we)           mem[a_addr] <= a_wdata;
  end

  // read-first output registers
  always_ff @(posedge clk) begin
    if (rst)       a_rdata <= '0;
    else if (a_re) a_rdata <= mem[a_addr];
  end

  always_ff @(posedge clk) begin
    if (rst)       b_rdata <= '0;
    else if (b_re) b_rdata <= mem[b_addr];
  end

endmodule

// File: rtl/twin_port_ram.sv
module twin_port_ram
  import twin_port_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              l_cs_n,
  input  logic              l_oe_n,
  input  logic              l_read,
  input  logic              l_hold_n,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  output logic              l_rvalid,
  output logic              l_standby,
  input  logic              r_cs_n,
  input  logic              r_oe_n,
  input  logic              r_read,
  input  logic              r_hold_n,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata,
  output logic              r_rvalid,
  output logic              r_standby
);

  localparam int NPORTS = 2;

  port_ctl_t         ctl [NPORTS];
  logic [NPORTS-1:0] we_v;
  logic [NPORTS-1:0] re_v;
  logic [NPORTS-1:0] rvalid_v;
  logic [NPORTS-1:0] standby_v;

  assign ctl[0] = '{cs_n: l_cs_n, oe_n: l_oe_n, read: l_read, hold_n: l_hold_n};
  assign ctl[1] = '{cs_n: r_cs_n, oe_n: r_oe_n, read: r_read, hold_n: r_hold_n};

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    port_decode u_dec (
      .clk     (clk),
      .rst     (rst),
      .ctl     (ctl[p]),
      .rd_en   (re_v[p]),
      .wr_en   (we_v[p]),
      .rvalid  (rvalid_v[p]),
      .standby (standby_v[p])
    );
  end

  twin_port_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk     (clk),
    .rst     (rst),
    .a_addr  (l_addr),
    .a_wdata (l_wdata),
    .a_we    (we_v[0]),
    .a_re    (re_v[0]),
    .a_rdata (l_rdata),
    .b_addr  (r_addr),
    .b_wdata (r_wdata),
    .b_we    (we_v[1]),
    .b_re    (re_v[1]),
    .b_rdata (r_rdata)
  );

  assign l_rvalid  = rvalid_v[0];
  assign r_rvalid  = rvalid_v[1];
  assign l_standby = standby_v[0];
  assign r_standby = standby_v[1];

endmodule

// File: rtl/twin_port_chk.sv
module twin_port_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              l_cs_n,
  input logic              l_oe_n,
  input logic              l_read,
  input logic              l_hold_n,
  input logic [DATA_W-1:0] l_rdata,
  input logic              l_rvalid,
  input logic              l_standby,
  input logic              l_we,
  input logic              r_cs_n,
  input logic              r_oe_n,
  input logic              r_read,
  input logic              r_hold_n,
  input logic [DATA_W-1:0] r_rdata,
  input logic              r_rvalid,
  input logic              r_standby,
  input logic              r_we
);

  logic l_acc, r_acc;
  assign l_acc = !l_cs_n && l_read && !l_oe_n;
  assign r_acc = !r_cs_n && r_read && !r_oe_n;

  assert_l_valid_src_R2: assert property (@(posedge clk) disable iff (rst)
    l_rvalid |-> $past(l_acc));
  assert_r_valid_src_R2: assert property (@(posedge clk) disable iff (rst)
    r_rvalid |-> $past(r_acc));

  assert_l_oe_gate_R3: assert property (@(posedge clk) disable iff (rst)
    l_oe_n |=> !l_rvalid);
  assert_r_oe_gate_R3: assert property (@(posedge clk) disable iff (rst)
    r_oe_n |=> !r_rvalid);

  assert_l_rdata_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(l_acc)) |-> $stable(l_rdata));
  assert_r_rdata_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(r_acc)) |-> $stable(r_rdata));

  assert_l_hold_block_R6: assert property (@(posedge clk) disable iff (rst)
    !l_hold_n |-> !l_we);
  assert_r_hold_block_R6: assert property (@(posedge clk) disable iff (rst)
    !r_hold_n |-> !r_we);

  assert_l_desel_idle_R7: assert property (@(posedge clk) disable iff (rst)
    l_cs_n |-> !l_we);
  assert_r_desel_idle_R7: assert property (@(posedge clk) disable iff (rst)
    r_cs_n |-> !r_we);

  assert_l_standby_R9: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (l_standby == $past(l_cs_n)));
  assert_r_standby_R9: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (r_standby == $past(r_cs_n)));

endmodule

bind twin_port_ram twin_port_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .l_cs_n    (l_cs_n),
  .l_oe_n    (l_oe_n),
  .l_read    (l_read),
  .l_hold_n  (l_hold_n),
  .l_rdata   (l_rdata),
  .l_rvalid  (l_rvalid),
  .l_standby (l_standby),
  .l_we      (we_v[0]),
  .r_cs_n    (r_cs_n),
  .r_oe_n    (r_oe_n),
  .r_read    (r_read),
  .r_hold_n  (r_hold_n),
  .r_rdata   (r_rdata),
  .r_rvalid  (r_rvalid),
  .r_standby (r_standby),
  .r_we      (we_v[1])
);

// File: tb/twin_port_ram_tb.sv
`timescale 1ns/1ps
module twin_port_ram_tb;

  localparam logic [1:0] OP_WR = 2'd0;  // write, hold released
  localparam logic [1:0] OP_RD = 2'd1;  // read, output enabled
  localparam logic [1:0] OP_HW = 2'd2;  // write with hold low
  localparam logic [1:0] OP_OH = 2'd3;  // read with output enable high

  typedef struct packed {
    logic       side;   // 0 left, 1 right
    logic [1:0] op;
    logic [9:0] addr;
    logic [7:0] data;
  } vec_t;

  localparam int NVEC = 16;
  localparam vec_t VEC [NVEC] = '{
    '{1'b0, OP_WR, 10'h000, 8'hA5},
    '{1'b1, OP_WR, 10'h3FF, 8'h5A},
    '{1'b1, OP_RD, 10'h000, 8'h00},
    '{1'b0, OP_RD, 10'h3FF, 8'h00},
    '{1'b0, OP_HW, 10'h000, 8'hFF},
    '{1'b1, OP_RD, 10'h000, 8'h00},
    '{1'b1, OP_WR, 10'h155, 8'h3C},
    '{1'b1, OP_OH, 10'h155, 8'h00},
    '{1'b0, OP_RD, 10'h155, 8'h00},
    '{1'b1, OP_HW, 10'h3FF, 8'h00},
    '{1'b0, OP_RD, 10'h3FF, 8'h00},
    '{1'b0, OP_WR, 10'h2AA, 8'h81},
    '{1'b1, OP_RD, 10'h2AA, 8'h00},
    '{1'b0, OP_OH, 10'h2AA, 8'h00},
    '{1'b1, OP_WR, 10'h000, 8'h42},
    '{1'b0, OP_RD, 10'h000, 8'h00}
  };

  logic       clk = 1'b0;
  logic       rst;
  logic       l_cs_n, l_oe_n, l_read, l_hold_n;
  logic [9:0] l_addr;
  logic [7:0] l_wdata;
  logic [7:0] l_rdata;
  logic       l_rvalid, l_standby;
  logic       r_cs_n, r_oe_n, r_read, r_hold_n;
  logic [9:0] r_addr;
  logic [7:0] r_wdata;
  logic [7:0] r_rdata;
  logic       r_rvalid, r_standby;

  always #4 clk = ~clk;

  twin_port_ram u_dut (
    .clk(clk), .rst(rst),
    .l_cs_n(l_cs_n), .l_oe_n(l_oe_n), .l_read(l_read), .l_hold_n(l_hold_n),
    .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata),
    .l_rvalid(l_rvalid), .l_standby(l_standby),
    .r_cs_n(r_cs_n), .r_oe_n(r_oe_n), .r_read(r_read), .r_hold_n(r_hold_n),
    .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata),
    .r_rvalid(r_rvalid), .r_standby(r_standby)
  );

  int         total = 0;
  int         bad   = 0;
  logic [7:0] ref_mem [1024];
  logic [7:0] last_rd [2];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle_both();
    l_cs_n = 1'b1; l_oe_n = 1'b1; l_read = 1'b1; l_hold_n = 1'b1;
    l_addr = '0;   l_wdata = '0;
    r_cs_n = 1'b1; r_oe_n = 1'b1; r_read = 1'b1; r_hold_n = 1'b1;
    r_addr = '0;   r_wdata = '0;
  endtask

  task automatic drive(input logic side, input logic cs_n, input logic oe_n,
                       input logic rd, input logic hold_n,
                       input logic [9:0] a, input logic [7:0] d);
    if (!side) begin
      l_cs_n = cs_n; l_oe_n = oe_n; l_read = rd; l_hold_n = hold_n;
      l_addr = a; l_wdata = d;
    end else begin
      r_cs_n = cs_n; r_oe_n = oe_n; r_read = rd; r_hold_n = hold_n;
      r_addr = a; r_wdata = d;
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle_both();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R10 reset state
    chk("R10 l_rvalid", {31'b0, l_rvalid}, 32'd0);
    chk("R10 r_rvalid", {31'b0, r_rvalid}, 32'd0);
    chk("R10 l_rdata", {24'b0, l_rdata}, 32'h00);
    chk("R10 r_rdata", {24'b0, r_rdata}, 32'h00);
    chk("R10 l_standby", {31'b0, l_standby}, 32'd1);
    chk("R10 r_standby", {31'b0, r_standby}, 32'd1);
    last_rd[0] = 8'h00;
    last_rd[1] = 8'h00;

    // vector table, one side active per entry
    for (int i = 0; i < NVEC; i++) begin
      vec_t v;
      logic [7:0] got;
      logic       gv;
      v = VEC[i];
      idle_both();
      case (v.op)
        OP_WR: drive(v.side, 1'b0, 1'b1, 1'b0, 1'b1, v.addr, v.data);
        OP_RD: drive(v.side, 1'b0, 1'b0, 1'b1, 1'b1, v.addr, v.data);
        OP_HW: drive(v.side, 1'b0, 1'b1, 1'b0, 1'b0, v.addr, v.data);
        default: drive(v.side, 1'b0, 1'b1, 1'b1, 1'b1, v.addr, v.data);
      endcase
      step();
      got = v.side ? r_rdata : l_rdata;
      gv  = v.side ? r_rvalid : l_rvalid;
      case (v.op)
        OP_RD: begin
          chk($sformatf("R2 R1 vec%0d rdata", i), {24'b0, got}, {24'b0, ref_mem[v.addr]});
          chk($sformatf("R2 vec%0d rvalid", i), {31'b0, gv}, 32'd1);
          last_rd[v.side] = ref_mem[v.addr];
        end
        OP_WR: begin
          ref_mem[v.addr] = v.data;
          chk($sformatf("R3 vec%0d rvalid during write", i), {31'b0, gv}, 32'd0);
        end
        OP_HW: begin
          chk($sformatf("R6 vec%0d rvalid", i), {31'b0, gv}, 32'd0);
        end
        default: begin
          chk($sformatf("R3 vec%0d rvalid oe high", i), {31'b0, gv}, 32'd0);
          chk($sformatf("R4 vec%0d rdata held", i), {24'b0, got}, {24'b0, last_rd[v.side]});
        end
      endcase
    end

    // R9 standby follows select one clock later
    idle_both();
    step();
    drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 10'h0, 8'h0);
    chk("R9 l_standby before edge", {31'b0, l_standby}, 32'd1);
    step();
    chk("R9 l_standby after edge", {31'b0, l_standby}, 32'd0);
    chk("R9 r_standby idle", {31'b0, r_standby}, 32'd1);

    // R8 same-address double write: left stored
    idle_both();
    drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 10'h100, 8'h11);
    drive(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 10'h100, 8'h22);
    step();
    idle_both();
    drive(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 10'h100, 8'h0);
    step();
    chk("R8 left wins collision", {24'b0, r_rdata}, 32'h11);

    // R2 read-first: left reads while right writes same word
    idle_both();
    drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 10'h100, 8'h0);
    drive(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 10'h100, 8'h33);
    step();
    chk("R2 read sees old word", {24'b0, l_rdata}, 32'h11);
    idle_both();
    drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 10'h100, 8'h0);
    step();
    chk("R2 next read sees new word", {24'b0, l_rdata}, 32'h33);

    // R5 write with output enable low still writes; R3 no valid
    idle_both();
    drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 10'h200, 8'h77);
    step();
    chk("R3 rvalid low while writing oe low", {31'b0, l_rvalid}, 32'd0);
    // R7 deselected right side with read line low writes nothing
    idle_both();
    drive(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 10'h200, 8'h99);
    step();
    chk("R7 deselected rvalid", {31'b0, r_rvalid}, 32'd0);
    idle_both();
    drive(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 10'h200, 8'h0);
    step();
    chk("R5 R7 word after oe-low write and deselected write", {24'b0, r_rdata}, 32'h77);

    // R4 rdata held through idle cycles
    idle_both();
    step();
    step();
    chk("R4 r_rdata held when idle", {24'b0, r_rdata}, 32'h77);
    chk("R3 r_rvalid low when idle", {31'b0, r_rvalid}, 32'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule